// File: doc/BRIEF.md
# Buffered SPI Master Shifter

This block is an 8-bit SPI master for a processor bus. A bus write either starts a byte at once, when the shifter is idle, or parks the byte in a one-byte transmit holding register. A bus read returns the last byte received. When a byte completes, a holding register that has been written starts the next transfer on the following clock, so consecutive bytes go out with no idle gap.

The serial side drives SCK and MOSI and samples MISO. A 2-bit rate select chooses one of four bit periods. Two further inputs set the SCK idle level and the edge on which data is sampled. The processor drives slave select itself through a separate pin. The block gives a holding-register-full flag, a busy flag, a receive-overrun flag and a one-cycle completion pulse.

Top module: `spi_master_buf`

## Requirements
- R1: A write (`wr_en` high at a clock edge) while `busy` and `tx_full` are both low loads the byte straight into the shifter. From the next cycle `busy` is high and `tx_full` stays low.
- R2: A write while `busy` is high stores the byte in the holding register and raises `tx_full`. A second write while `tx_full` is high replaces the stored byte, so only the latest byte is sent.
- R3: When a byte completes with `tx_full` high (or with a write in that same cycle), the held byte starts on the next cycle. `busy` stays high with no gap and `tx_full` falls.
- R4: Each byte gives exactly 8 SCK pulses and shifts 8 bits out on MOSI, MSB first. While `busy` is low, SCK rests at `cpol`.
- R5: At the clock edge that ends the eighth bit, the 8 sampled MISO bits (first bit as MSB) appear on `rdata`, and `done_irq` is high for exactly that one following cycle.
- R6: A completion while the receive register holds a byte that has not been read sets `overrun`. A cycle with `rd_en` high and no completion marks the register read and clears `overrun`.
- R7: `rate_sel` values 0, 1, 2 and 3 give bit periods of 3, 6, 12 and 48 clocks. At 3 the SCK active level lasts 1 clock out of 3. At the other rates it lasts half the period.
- R8: With `cpha` = 0, MOSI holds each bit from the start of its period and MISO is sampled at the first SCK edge of the bit. With `cpha` = 1, MOSI changes at the first edge and MISO is sampled at the second edge.
- R9: After reset, `busy`, `tx_full`, `done_irq` and `overrun` are low, `rdata` is 0 and SCK equals `cpol`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Bus write strobe for the data register |
| wdata | input | 8 | Bus write data |
| rd_en | input | 1 | Bus read strobe, marks the receive byte as read |
| rdata | output | 8 | Receive register contents |
| rate_sel | input | 2 | Bit-period select; hold stable while busy |
| cpol | input | 1 | SCK idle level; hold stable while busy |
| cpha | input | 1 | Sampling edge select; hold stable while busy |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| tx_full | output | 1 | Holding register occupied |
| busy | output | 1 | Shifter holds an active byte |
| overrun | output | 1 | An unread receive byte was overwritten |
| done_irq | output | 1 | One-cycle byte completion pulse |

## Verification
A wrong phase or bit counter shows on SCK within one bit period, as a pulse of the wrong width or a ninth pulse. It also shows as a completion pulse that comes too early or too late. A shifter that has lost its position shows on MOSI at the next bit boundary, and on `rdata` when the byte ends. A stuck holding flag shows as a chained byte that never starts, or that starts twice, and `busy` reveals it in the cycle after completion. Because the reference model compares all outputs on every clock, each of these faults is reported in the cycle where it first reaches a port.

// File: rtl/spi_master_buf.sv
module spi_master_buf #(
  parameter int WIDTH = 8,
  parameter int DIV_0 = 3,
  parameter int DIV_1 = 6,
  parameter int DIV_2 = 12,
  parameter int DIV_3 = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wdata,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rdata,
  input  logic [1:0]       rate_sel,
  input  logic             cpol,
  input  logic             cpha,
  output logic             sck,
  output logic             mosi,
  input  logic             miso,
  output logic             tx_full,
  output logic             busy,
  output logic             overrun,
  output logic             done_irq
);
  localparam int CW = $clog2(DIV_3 + 1);
  localparam int BW = $clog2(WIDTH);
  localparam logic [CW-1:0] P0 = CW'(DIV_0), P1 = CW'(DIV_1);
  localparam logic [CW-1:0] P2 = CW'(DIV_2), P3 = CW'(DIV_3);
  localparam logic [CW-1:0] L0 = CW'(DIV_0 - DIV_0 / 3), L1 = CW'(DIV_1 / 2);
  localparam logic [CW-1:0] L2 = CW'(DIV_2 / 2), L3 = CW'(DIV_3 / 2);

  logic [CW-1:0]    per, lead, cnt_q;
  logic [BW-1:0]    bit_q;
  logic [WIDTH-1:0] sh_q, tb_q, rx_q, tb_d;
  logic             busy_q, tf_q, unread_q, ovr_q, irq_q, smp_q, mq_q;
  logic             bit_end, last, lead_hit, tf_d, din, load;

  always_comb begin
    case (rate_sel)
      2'd0:    begin per = P0; lead = L0; end
      2'd1:    begin per = P1; lead = L1; end
      2'd2:    begin per = P2; lead = L2; end
      default: begin per = P3; lead = L3; end
    endcase
  end

  assign bit_end  = busy_q && (cnt_q == per - 1'b1);
  assign last     = bit_end && (bit_q == BW'(WIDTH - 1));
  assign lead_hit = busy_q && (cnt_q == lead - 1'b1);
  assign tb_d     = wr_en ? wdata : tb_q;
  assign tf_d     = wr_en | tf_q;
  assign din      = cpha ? miso : smp_q;
  assign load     = (!busy_q || last) && tf_d;

  assign sck      = cpol ^ (busy_q && (cnt_q >= lead));
  assign mosi     = cpha ? mq_q : sh_q[WIDTH-1];
  assign rdata    = rx_q;
  assign tx_full  = tf_q;
  assign busy     = busy_q;
  assign overrun  = ovr_q;
  assign done_irq = irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; cnt_q <= '0; bit_q <= '0;
      sh_q <= '0; tb_q <= '0; tf_q <= 1'b0;
      smp_q <= 1'b0; mq_q <= 1'b0;
    end else begin
      if (lead_hit) begin
        smp_q <= miso;
        mq_q  <= sh_q[WIDTH-1];
      end
      if (load) begin
        sh_q   <= tb_d;
        busy_q <= 1'b1;
        cnt_q  <= '0;
        bit_q  <= '0;
        tf_q   <= 1'b0;
      end else begin
        tb_q <= tb_d;
        tf_q <= tf_d;
        if (last) busy_q <= 1'b0;
        if (bit_end) begin
          sh_q  <= {sh_q[WIDTH-2:0], din};
          cnt_q <= '0;
          bit_q <= bit_q + 1'b1;
        end else if (busy_q) begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q <= '0; unread_q <= 1'b0; ovr_q <= 1'b0; irq_q <= 1'b0;
    end else begin
      irq_q <= last;
      if (last) begin
        rx_q     <= {sh_q[WIDTH-2:0], din};
        unread_q <= 1'b1;
        ovr_q    <= ovr_q | unread_q;
      end else if (rd_en) begin
        unread_q <= 1'b0;
        ovr_q    <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/spi_master_buf_chk.sv
module spi_master_buf_chk (
  input logic clk,
  input logic rst_n,
  input logic rd_en,
  input logic cpol,
  input logic sck,
  input logic busy,
  input logic tx_full,
  input logic done_irq,
  input logic overrun
);
  p_sck_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sck == cpol);
  p_full_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_full |-> busy);
  p_irq_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |=> !done_irq);
  p_fall_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done_irq);
  p_chain_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done_irq && $past(tx_full)) |-> busy);
  p_ovr_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> (!overrun || done_irq));
endmodule

bind spi_master_buf spi_master_buf_chk u_chk (.*);

// File: tb/spi_master_buf_tb.sv
module spi_master_buf_tb;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic [1:0] rate_sel = 2'd0;
  logic cpol = 1'b0, cpha = 1'b0, miso = 1'b0;
  logic sck, mosi, tx_full, busy, overrun, done_irq;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  spi_master_buf u_dut (.*);

  function automatic int per_of(input logic [1:0] r);
    return (r == 0) ? 3 : (r == 1) ? 6 : (r == 2) ? 12 : 48;
  endfunction
  function automatic int act_of(input logic [1:0] r);
    return (r == 0) ? 1 : per_of(r) / 2;
  endfunction
  function automatic logic [7:0] slv_of(input int n);
    return 8'h3C ^ 8'(n * 29);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference
  int m_cnt, m_bit, m_nl;
  bit m_busy, m_tf, m_unread, m_ovr, m_irq, m_smp, m_mq;
  logic [7:0] m_sh, m_tb, m_rx, m_slv;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_bit = 0; m_nl = 0; m_busy = 0; m_tf = 0; m_unread = 0;
      m_ovr = 0; m_irq = 0; m_smp = 0; m_mq = 0; m_sh = 0; m_tb = 0; m_rx = 0; m_slv = 0;
    end else begin
      int p, ld;
      bit fin, tfn, d, go;
      logic [7:0] tbn;
      p = per_of(rate_sel);
      ld = p - act_of(rate_sel);
      fin = m_busy && m_cnt == p - 1 && m_bit == 7;
      tbn = wr_en ? wdata : m_tb;
      tfn = wr_en || m_tf;
      d = cpha ? miso : m_smp;
      go = (!m_busy || fin) && tfn;
      m_irq = fin;
      if (fin) begin
        m_rx = {m_sh[6:0], d}; m_ovr = m_ovr | m_unread; m_unread = 1;
      end else if (rd_en) begin
        m_unread = 0; m_ovr = 0;
      end
      if (m_busy && m_cnt == ld - 1) begin m_smp = miso; m_mq = m_sh[7]; end
      if (m_busy && m_cnt == p - 1) begin
        m_sh = {m_sh[6:0], d}; m_cnt = 0; m_bit++;
      end else if (m_busy) m_cnt++;
      if (go) begin
        m_sh = tbn; m_busy = 1; m_cnt = 0; m_bit = 0; m_tf = 0;
        m_slv = slv_of(m_nl); m_nl++;
      end else begin
        m_tb = tbn; m_tf = tfn;
        if (fin) m_busy = 0;
      end
    end
  end

  always @(negedge clk) miso <= m_busy ? m_slv[7 - m_bit] : 1'b0;

  always @(negedge clk) if (rst_n) begin
    bit es;
    es = cpol ^ (m_busy && m_cnt >= per_of(rate_sel) - act_of(rate_sel));
    check(sck == es, "R4 sck", sck, es);
    check(mosi == (cpha ? m_mq : m_sh[7]), "R8 mosi", mosi, cpha ? m_mq : m_sh[7]);
    check(busy == m_busy, "R1 busy", busy, m_busy);
    check(tx_full == m_tf, "R2 tx_full", tx_full, m_tf);
    check(done_irq == m_irq, "R5 done_irq", done_irq, m_irq);
    check(rdata == m_rx, "R5 rdata", rdata, m_rx);
    check(overrun == m_ovr, "R6 overrun", overrun, m_ovr);
  end

  task automatic wr(input logic [7:0] d);
    wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd();
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  int nl = 0;

  task automatic single(input logic [7:0] d, input logic [1:0] r, input logic pol, input logic ph);
    int bc = 0, ac = 0, rises = 0;
    logic prev;
    rate_sel = r; cpol = pol; cpha = ph;
    @(negedge clk);
    wr(d);
    check(busy && !tx_full, "R1 start", {busy, tx_full}, 2);
    prev = sck;
    while (!done_irq) begin
      if (busy) bc++;
      if (sck != cpol) ac++;
      if (prev == cpol && sck != cpol) rises++;
      prev = sck;
      @(negedge clk);
    end
    check(rises == 8, "R4 pulses", rises, 8);
    check(bc == 8 * per_of(r), "R7 period", bc, 8 * per_of(r));
    check(ac == 8 * act_of(r), "R7 duty", ac, 8 * act_of(r));
    check(rdata == slv_of(nl), "R5 rx byte", rdata, slv_of(nl));
    nl++;
    rd();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !tx_full && !done_irq && !overrun && rdata == 0 && sck == cpol,
          "R9 reset", {busy, tx_full, done_irq, overrun}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    single(8'hA5, 2'd0, 1'b0, 1'b0);
    single(8'h3C, 2'd1, 1'b1, 1'b0);
    single(8'h81, 2'd2, 1'b0, 1'b1);
    single(8'h5A, 2'd3, 1'b1, 1'b1);
    single(8'hF0, 2'd0, 1'b1, 1'b1);
    begin
      bit gap = 0;
      int irqs = 0;
      rate_sel = 2'd1; cpol = 1'b0; cpha = 1'b1;
      @(negedge clk);
      wr(8'h11);
      wr(8'h22);
      check(tx_full == 1'b1, "R2 held", tx_full, 1);
      wr(8'hC3);
      check(tx_full == 1'b1, "R2 overwrite", tx_full, 1);
      while (irqs < 2) begin
        if (done_irq) begin
          irqs++;
          if (irqs == 1) begin
            check(rdata == slv_of(nl), "R5 first", rdata, slv_of(nl));
            check(busy && !tx_full, "R3 chained", {busy, tx_full}, 2);
          end
        end else if (irqs == 1 && !busy) gap = 1;
        @(negedge clk);
        if (irqs == 1 && !done_irq && !busy) gap = 1;
      end
      check(!gap, "R3 no gap", gap, 0);
      check(rdata == slv_of(nl + 1), "R5 second", rdata, slv_of(nl + 1));
      check(overrun == 1'b1, "R6 set", overrun, 1);
      @(negedge clk);
      check(!busy, "R2 only two bytes", busy, 0);
      rd();
      check(overrun == 1'b0, "R6 cleared", overrun, 0);
      nl += 2;
    end
    single(8'h00, 2'd2, 1'b1, 1'b0);
    repeat (4) @(negedge clk);
    check(sck == cpol && !busy, "R4 idle level", sck, cpol);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule